// File: doc/BRIEF.md
# Debug Transfer Register Access Controller

This block connects an external debugger, attached through an APB-style slave port, to a processor core. The debugger uses four word-addressed registers. One data register carries words from the debugger to the core, one carries words back, one takes an instruction for the core to run, and one holds control and status. The core side is a simple handshake. The block offers an instruction, the core reports that it has finished or aborted, the core pops inbound words, and it pushes outbound words when a ready flag allows.

A two-bit mode field changes how the debugger side behaves. In non-blocking mode no access ever waits: the debugger polls the status flags, and misuse is recorded in sticky error bits. In stall mode the bus is held with wait states until the addressed register can complete the access. Fast mode also holds the bus. In addition, every outbound data read that returns a word re-issues the last instruction, so a block transfer becomes a run of plain reads.

Top module: `dbg_xfer_ctrl`

## Requirements
- R1: The registers sit at word index 32 (inbound data, write), 33 (instruction, write), 34 (control/status, read/write) and 35 (outbound data, read). Every read other than index 34 or 35 returns zero, and a write to an index outside 32 to 34 has no effect.
- R2: Status bits [21:20] hold the mode and read back as written. 00 is non-blocking, 01 is stall and 10 is fast. The value 11 reads back as 11 but behaves as non-blocking.
- R3: After reset the status word reads 0x0100_0000: mode 00, both data registers empty, instruction-complete flag set, all sticky flags clear.
- R4: In non-blocking mode no access inserts wait states. A write to a full inbound register is dropped and sets sticky overrun bit 27. A read of an empty outbound register returns the last word and sets sticky underrun bit 26. Writing 1 to bit 27, 26 or 6 of the status register clears that bit.
- R5: In stall or fast mode, a write to a full inbound register holds pready low until the core pops it. The write then completes with the new word.
- R6: In stall or fast mode, a write to the instruction register while an instruction is outstanding holds pready low until that instruction completes. The new instruction is then issued.
- R7: In stall or fast mode, a read of an empty outbound register holds pready low until the core pushes a word. The read then returns that word.
- R8: In fast mode, each completed outbound read re-issues the last written instruction. Such a read also waits until no instruction is outstanding.
- R9: Status bit 24 (instruction complete) clears in the cycle after an instruction is issued. It sets in the cycle after the core reports completion, and core_insn_valid follows the opposite sense.
- R10: An abort from the core completes the instruction at once, in the same way as completion, and also sets sticky status bit 6. A following instruction write does not stall.
- R11: Status bit 30 shows the inbound register full and bit 29 shows the outbound register full. Both change in the cycle after the push or pop that alters them.
- R12: The core sees the inbound word on core_rx_data while core_rx_valid is high. core_tx_ready is high exactly while the outbound register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | AW | Word index |
| pwdata | input | DW | Write data |
| prdata | output | DW | Read data |
| pready | output | 1 | Low inserts a wait state |
| core_rx_valid | output | 1 | Inbound word available |
| core_rx_data | output | DW | Inbound word |
| core_rx_pop | input | 1 | Core takes inbound word |
| core_tx_ready | output | 1 | Outbound register empty |
| core_tx_push | input | 1 | Core writes outbound word |
| core_tx_data | input | DW | Outbound word |
| core_insn_valid | output | 1 | Instruction outstanding |
| core_insn | output | DW | Instruction word |
| core_insn_done | input | 1 | Instruction completed |
| core_insn_abort | input | 1 | Instruction aborted |

## Verification
The assertions assume that the core pulses done or abort only while core_insn_valid is high, and never both together. They also assume that pops and pushes follow core_rx_valid and core_tx_ready, and that bus signals stay steady through a stalled access phase. The bench core model raises each of these pulses for one cycle, and only when the matching flag permits it. Its bus task holds address, data and direction from the setup phase until pready is seen high.

// File: rtl/dbg_xfer_pkg.sv
`timescale 1ns/1ps
package dbg_xfer_pkg;

    typedef enum logic [1:0] {
        MODE_NB    = 2'b00,
        MODE_STALL = 2'b01,
        MODE_FAST  = 2'b10,
        MODE_RSVD  = 2'b11
    } xfer_mode_e;

    localparam int IDX_RX  = 32;
    localparam int IDX_ITR = 33;
    localparam int IDX_CTL = 34;
    localparam int IDX_TX  = 35;

    localparam int BIT_RXFULL  = 30;
    localparam int BIT_TXFULL  = 29;
    localparam int BIT_OVR     = 27;
    localparam int BIT_UDR     = 26;
    localparam int BIT_DONE    = 24;
    localparam int BIT_MODE_LO = 20;
    localparam int BIT_ABT     = 6;

    function automatic logic mode_waits(xfer_mode_e m);
        return (m == MODE_STALL) || (m == MODE_FAST);
    endfunction

endpackage

// File: rtl/dbg_data_slot.sv
`timescale 1ns/1ps
module dbg_data_slot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fill,
    input  logic [W-1:0] fill_data,
    input  logic         drain,
    output logic         full,
    output logic [W-1:0] data
);
    typedef struct packed {
        logic         full;
        logic [W-1:0] data;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (drain && st_q.full) begin
            st_d.full = 1'b0;
        end
        if (fill && !st_q.full) begin
            st_d.full = 1'b1;
            st_d.data = fill_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full = st_q.full;
    assign data = st_q.data;
endmodule

// File: rtl/dbg_insn_tracker.sv
`timescale 1ns/1ps
module dbg_insn_tracker #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         reissue,
    input  logic         done,
    input  logic         abort,
    output logic         busy,
    output logic         complete,
    output logic [W-1:0] insn,
    output logic         abort_seen
);
    typedef struct packed {
        logic         busy;
        logic         complete;
        logic [W-1:0] insn;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // an abort finishes the instruction exactly as a completion does
        if (st_q.busy && (done || abort)) begin
            st_d.busy     = 1'b0;
            st_d.complete = 1'b1;
        end
        if (load) begin
            st_d.insn     = load_data;
            st_d.busy     = 1'b1;
            st_d.complete = 1'b0;
        end
        if (reissue) begin
            st_d.busy     = 1'b1;
            st_d.complete = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.busy     <= 1'b0;
            st_q.complete <= 1'b1;
            st_q.insn     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = st_q.busy;
    assign complete   = st_q.complete;
    assign insn       = st_q.insn;
    assign abort_seen = st_q.busy && abort;
endmodule

// File: rtl/dbg_apb_decode.sv
`timescale 1ns/1ps
module dbg_apb_decode
    import dbg_xfer_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  xfer_mode_e    mode,
    input  logic          rx_full,
    input  logic          tx_full,
    input  logic          busy,
    output logic          pready,
    output logic          hit_ctl,
    output logic          hit_tx,
    output logic          rx_wr,
    output logic          itr_wr,
    output logic          ctl_wr,
    output logic          tx_rd,
    output logic          ovr_set,
    output logic          udr_set,
    output logic          reissue
);
    logic access, hit_rx, hit_itr, hold, fin;

    always_comb begin
        access  = psel && penable;
        hit_rx  = (paddr == AW'(IDX_RX));
        hit_itr = (paddr == AW'(IDX_ITR));
        hit_ctl = (paddr == AW'(IDX_CTL));
        hit_tx  = (paddr == AW'(IDX_TX));

        hold = 1'b0;
        if (mode_waits(mode)) begin
            if (hit_rx && pwrite && rx_full)   hold = 1'b1;
            if (hit_itr && pwrite && busy)     hold = 1'b1;
            if (hit_tx && !pwrite &&
                (!tx_full || (mode == MODE_FAST && busy))) hold = 1'b1;
        end

        pready  = !(access && hold);
        fin     = access && pready;

        rx_wr   = fin && hit_rx && pwrite && !rx_full;
        ovr_set = fin && hit_rx && pwrite && rx_full;
        itr_wr  = fin && hit_itr && pwrite && !busy;
        ctl_wr  = fin && hit_ctl && pwrite;
        tx_rd   = fin && hit_tx && !pwrite && tx_full;
        udr_set = fin && hit_tx && !pwrite && !tx_full;
        reissue = tx_rd && (mode == MODE_FAST);
    end
endmodule

// File: rtl/dbg_xfer_ctrl.sv
`timescale 1ns/1ps
module dbg_xfer_ctrl
    import dbg_xfer_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    output logic [DW-1:0] prdata,
    output logic          pready,
    output logic          core_rx_valid,
    output logic [DW-1:0] core_rx_data,
    input  logic          core_rx_pop,
    output logic          core_tx_ready,
    input  logic          core_tx_push,
    input  logic [DW-1:0] core_tx_data,
    output logic          core_insn_valid,
    output logic [DW-1:0] core_insn,
    input  logic          core_insn_done,
    input  logic          core_insn_abort
);
    typedef struct packed {
        xfer_mode_e mode;
        logic       ovr;
        logic       udr;
        logic       abt;
    } ctl_t;

    ctl_t st_d, st_q;

    logic          rx_full_w, tx_full_w, busy_w, complete_w, abort_seen;
    logic [DW-1:0] rx_data_w, tx_data_w, insn_w, status_w;
    logic          hit_ctl, hit_tx, rx_wr, itr_wr, ctl_wr, tx_rd;
    logic          ovr_set, udr_set, reissue;
    xfer_mode_e    mode_w;

    assign mode_w = st_q.mode;

    dbg_apb_decode #(.AW(AW)) u_dec (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .mode    (mode_w),
        .rx_full (rx_full_w),
        .tx_full (tx_full_w),
        .busy    (busy_w),
        .pready  (pready),
        .hit_ctl (hit_ctl),
        .hit_tx  (hit_tx),
        .rx_wr   (rx_wr),
        .itr_wr  (itr_wr),
        .ctl_wr  (ctl_wr),
        .tx_rd   (tx_rd),
        .ovr_set (ovr_set),
        .udr_set (udr_set),
        .reissue (reissue)
    );

    dbg_data_slot #(.W(DW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill      (rx_wr),
        .fill_data (pwdata),
        .drain     (core_rx_pop),
        .full      (rx_full_w),
        .data      (rx_data_w)
    );

    dbg_data_slot #(.W(DW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill      (core_tx_push),
        .fill_data (core_tx_data),
        .drain     (tx_rd),
        .full      (tx_full_w),
        .data      (tx_data_w)
    );

    dbg_insn_tracker #(.W(DW)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (itr_wr),
        .load_data  (pwdata),
        .reissue    (reissue),
        .done       (core_insn_done),
        .abort      (core_insn_abort),
        .busy       (busy_w),
        .complete   (complete_w),
        .insn       (insn_w),
        .abort_seen (abort_seen)
    );

    always_comb begin
        st_d = st_q;
        if (ctl_wr) begin
            st_d.mode = xfer_mode_e'(pwdata[BIT_MODE_LO +: 2]);
            if (pwdata[BIT_OVR]) st_d.ovr = 1'b0;
            if (pwdata[BIT_UDR]) st_d.udr = 1'b0;
            if (pwdata[BIT_ABT]) st_d.abt = 1'b0;
        end
        // a new event wins over a clear in the same cycle
        if (ovr_set)    st_d.ovr = 1'b1;
        if (udr_set)    st_d.udr = 1'b1;
        if (abort_seen) st_d.abt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= MODE_NB;
            st_q.ovr  <= 1'b0;
            st_q.udr  <= 1'b0;
            st_q.abt  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status_w                     = '0;
        status_w[BIT_RXFULL]         = rx_full_w;
        status_w[BIT_TXFULL]         = tx_full_w;
        status_w[BIT_OVR]            = st_q.ovr;
        status_w[BIT_UDR]            = st_q.udr;
        status_w[BIT_DONE]           = complete_w;
        status_w[BIT_MODE_LO +: 2]   = st_q.mode;
        status_w[BIT_ABT]            = st_q.abt;

        prdata = '0;
        if (!pwrite) begin
            if (hit_ctl)     prdata = status_w;
            else if (hit_tx) prdata = tx_data_w;
        end
    end

    assign core_rx_valid   = rx_full_w;
    assign core_rx_data    = rx_data_w;
    assign core_tx_ready   = !tx_full_w;
    assign core_insn_valid = busy_w;
    assign core_insn       = insn_w;
endmodule

// File: rtl/dbg_xfer_ctrl_chk.sv
`timescale 1ns/1ps
module dbg_xfer_ctrl_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          psel,
    input logic          penable,
    input logic          pwrite,
    input logic [AW-1:0] paddr,
    input logic          pready,
    input logic [1:0]    mode,
    input logic          rx_full,
    input logic          busy,
    input logic          core_insn_valid,
    input logic          core_insn_done,
    input logic          core_insn_abort
);
    logic acc;
    assign acc = psel && penable;

    assert_nb_nostall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (mode == 2'b00 || mode == 2'b11)) |-> pready);

    assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pwrite && paddr == AW'(32) && (mode == 2'b01 || mode == 2'b10) && rx_full)
        |-> !pready);

    assert_itr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pwrite && paddr == AW'(33) && (mode == 2'b01 || mode == 2'b10) && busy)
        |-> !pready);

    assert_fast_reissue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pready && !pwrite && paddr == AW'(35) && mode == 2'b10)
        |=> core_insn_valid);

    assert_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pready && pwrite && paddr == AW'(33) && !busy) |=> core_insn_valid);

    assert_finish_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (core_insn_valid && (core_insn_done || core_insn_abort)) |=> !core_insn_valid);
endmodule

bind dbg_xfer_ctrl dbg_xfer_ctrl_chk #(.AW(AW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .psel            (psel),
    .penable         (penable),
    .pwrite          (pwrite),
    .paddr           (paddr),
    .pready          (pready),
    .mode            (mode_w),
    .rx_full         (rx_full_w),
    .busy            (busy_w),
    .core_insn_valid (core_insn_valid),
    .core_insn_done  (core_insn_done),
    .core_insn_abort (core_insn_abort)
);

// File: tb/dbg_xfer_ctrl_tb.sv
`timescale 1ns/1ps
module dbg_xfer_ctrl_tb;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [31:0] DONE_B = 32'h0100_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0, prdata;
    logic pready;
    logic core_rx_valid, core_tx_ready, core_insn_valid;
    logic [DW-1:0] core_rx_data, core_insn;
    logic core_rx_pop = 0, core_tx_push = 0, core_insn_done = 0, core_insn_abort = 0;
    logic [DW-1:0] core_tx_data = '0;

    int nchecks = 0, nerr = 0, cycles = 0;

    always #5 clk = ~clk;

    dbg_xfer_ctrl #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .core_rx_valid(core_rx_valid), .core_rx_data(core_rx_data), .core_rx_pop(core_rx_pop),
        .core_tx_ready(core_tx_ready), .core_tx_push(core_tx_push), .core_tx_data(core_tx_data),
        .core_insn_valid(core_insn_valid), .core_insn(core_insn),
        .core_insn_done(core_insn_done), .core_insn_abort(core_insn_abort)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            nchecks++; nerr++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apb(input logic wr, input int idx, input logic [31:0] wd,
                       output logic [31:0] rd, output int waits);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = wr; paddr = idx[AW-1:0]; pwdata = wd;
        @(negedge clk);
        penable = 1; waits = 0; #1;
        while (!pready) begin
            @(negedge clk); #1; waits++;
        end
        rd = prdata;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic pulse_pop();
        @(negedge clk); core_rx_pop = 1; @(negedge clk); core_rx_pop = 0;
    endtask
    task automatic pulse_push(input logic [31:0] d);
        @(negedge clk); core_tx_push = 1; core_tx_data = d; @(negedge clk); core_tx_push = 0;
    endtask
    task automatic pulse_done();
        @(negedge clk); core_insn_done = 1; @(negedge clk); core_insn_done = 0;
    endtask
    task automatic pulse_abort();
        @(negedge clk); core_insn_abort = 1; @(negedge clk); core_insn_abort = 0;
    endtask

    logic [31:0] rd, st;
    int w;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R3 reset state, R1 decode
        apb(0, 34, 0, st, w); chk("R3 reset status", st, DONE_B);
        chk("R12 tx ready at reset", {31'b0, core_tx_ready}, 32'd1);
        apb(0, 36, 0, rd, w); chk("R1 unused index reads zero", rd, 0);
        apb(0, 32, 0, rd, w); chk("R1 data-in reads zero", rd, 0);
        apb(1, 40, 32'hFFFF_FFFF, rd, w);
        apb(0, 34, 0, st, w); chk("R1 stray write no effect", st, DONE_B);

        // R2 mode sweep
        for (int m = 0; m < 4; m++) begin
            apb(1, 34, m << 20, rd, w);
            apb(0, 34, 0, st, w);
            chk("R2 mode readback", st, DONE_B | (m << 20));
        end

        // R4, R11, R12 in non-blocking (0) and reserved (3) modes
        for (int m = 0; m < 4; m += 3) begin
            apb(1, 34, m << 20, rd, w);
            for (int k = 0; k < 3; k++) begin
                logic [31:0] pat;
                pat = 32'h1357_0000 + k * 32'h0101_0111;
                apb(1, 32, pat, rd, w);
                chk("R12 rx data", core_rx_data, pat);
                chk("R12 rx valid", {31'b0, core_rx_valid}, 1);
                apb(0, 34, 0, st, w);
                chk("R11 rx full bit", st, DONE_B | (m << 20) | (1 << 30));
                apb(1, 32, ~pat, rd, w);
                chk("R4 no wait on full write", w, 0);
                chk("R4 dropped write", core_rx_data, pat);
                apb(0, 34, 0, st, w);
                chk("R4 overrun set", st, DONE_B | (m << 20) | (1 << 30) | (1 << 27));
                pulse_pop();
                apb(1, 34, (m << 20) | (1 << 27), rd, w);
                apb(0, 34, 0, st, w);
                chk("R4 overrun cleared, R11 rx empty", st, DONE_B | (m << 20));
            end
        end

        // R4 underrun, R11 tx full
        apb(1, 34, 0, rd, w);
        pulse_push(32'hA5A5_0F0F);
        chk("R12 tx ready low", {31'b0, core_tx_ready}, 0);
        apb(0, 34, 0, st, w); chk("R11 tx full bit", st, DONE_B | (1 << 29));
        apb(0, 35, 0, rd, w); chk("R4 tx read data", rd, 32'hA5A5_0F0F);
        apb(0, 35, 0, rd, w);
        chk("R4 empty read old value", rd, 32'hA5A5_0F0F);
        chk("R4 empty read no wait", w, 0);
        apb(0, 34, 0, st, w); chk("R4 underrun set", st, DONE_B | (1 << 26));
        apb(1, 34, 1 << 26, rd, w);

        // R9 issue and completion
        apb(1, 33, 32'hEE00_1234, rd, w);
        chk("R9 insn valid", {31'b0, core_insn_valid}, 1);
        chk("R9 insn word", core_insn, 32'hEE00_1234);
        apb(0, 34, 0, st, w); chk("R9 complete clear", st, 0);
        pulse_done();
        apb(0, 34, 0, st, w); chk("R9 complete set", st, DONE_B);

        // stall mode
        apb(1, 34, 1 << 20, rd, w);
        apb(1, 32, 32'h0000_0011, rd, w); chk("R5 empty write no wait", w, 0);
        fork
            apb(1, 32, 32'h0000_0022, rd, w);
            begin repeat (4) @(negedge clk); pulse_pop(); end
        join
        chk("R5 full write waited", {31'b0, (w > 0)}, 1);
        chk("R5 new word landed", core_rx_data, 32'h0000_0022);
        pulse_pop();

        apb(1, 33, 32'h1111_0001, rd, w);
        fork
            apb(1, 33, 32'h2222_0002, rd, w);
            begin repeat (4) @(negedge clk); pulse_done(); end
        join
        chk("R6 busy write waited", {31'b0, (w > 0)}, 1);
        chk("R6 second insn issued", core_insn, 32'h2222_0002);
        chk("R6 insn outstanding", {31'b0, core_insn_valid}, 1);
        pulse_done();

        fork
            apb(0, 35, 0, rd, w);
            begin repeat (4) @(negedge clk); pulse_push(32'hCAFE_0001); end
        join
        chk("R7 empty read waited", {31'b0, (w > 0)}, 1);
        chk("R7 read data", rd, 32'hCAFE_0001);

        // R10 abort
        apb(1, 33, 32'h3333_0003, rd, w);
        pulse_abort();
        apb(0, 34, 0, st, w);
        chk("R10 abort completes", st, DONE_B | (1 << 20) | (1 << 6));
        apb(1, 33, 32'h4444_0004, rd, w);
        chk("R10 no stall after abort", w, 0);
        pulse_done();
        apb(1, 34, (1 << 20) | (1 << 6), rd, w);
        apb(0, 34, 0, st, w); chk("R10 abort flag cleared", st, DONE_B | (1 << 20));

        // R8 fast mode block read
        apb(1, 33, 32'hECB0_5E01, rd, w);
        apb(1, 34, 2 << 20, rd, w);
        for (int i = 0; i < 3; i++) begin
            logic [31:0] dv;
            dv = 32'h5000_0000 + i * 32'h11;
            fork
                apb(0, 35, 0, rd, w);
                begin repeat (2) @(negedge clk); pulse_push(dv); pulse_done(); end
            join
            chk("R8 fast read data", rd, dv);
            chk("R8 reissued", {31'b0, core_insn_valid}, 1);
            chk("R8 same insn", core_insn, 32'hECB0_5E01);
        end
        apb(1, 34, 0, rd, w);
        apb(0, 34, 0, st, w); chk("R9 final insn pending", st, 0);
        pulse_done();
        apb(0, 34, 0, st, w); chk("R9 final insn complete", st, DONE_B);

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end
endmodule